// File: doc/BRIEF.md
# Comparator Gain Calibration Controller

This controller trims the two integrator-path gains of a three-input comparator used in a noise-shaping successive-approximation converter. The aim is for the path carrying the first integrator output to weigh four times the DAC path, and for the path carrying the second integrator output to weigh sixteen times the DAC path. Each integrator path has its own 3-bit gain code. The controller computes both codes by comparing a DAC residue with a charge-shared copy of that same residue.

Each trial runs in two steps. In the first step the controller applies a fixed pair of DAC codes. It then strobes the residue-sample switch and the charge-share switches, which leaves one quarter of the residue on the first integrator inputs (first path) or one sixteenth on the second integrator inputs (second path). In the second step the controller drives the bitwise complement of the fixed codes, so the DAC contribution has the opposite polarity, and fires the comparator once.

The comparator decision tells the controller which way the gain code must move. The search ends when the decision changes sign or when the code reaches an end of its range. The first path is always calibrated before the second. The results stay on the outputs until software requests a new calibration.

Top module: `cmp_gain_cal`

## Requirements
- R1: After reset both gain codes are 3'b100, `cal_done`, both `cal_sat` bits, every strobe and both hold outputs are 0, and both DAC code outputs are 0.
- R2: A `cal_start` pulse seen while no calibration is running clears `cal_done` and `cal_sat`, sets both gain codes back to 3'b100 and begins a calibration.
- R3: A first-path trial takes six cycles. Counting the cycle after the start edge as cycle 1: cycle 1 drives the fixed codes with no strobe; cycle 2 drives `res_sample`; cycle 3 drives `int1_share`; cycle 4 drives the complemented codes with no strobe; cycle 5 drives `cmp_fire` with the complemented codes; cycle 6 takes the decision. The fixed codes stay on the DAC outputs through the sample and share cycles.
- R4: A second-path trial places one `int2_share` cycle directly after `int1_share` and is seven cycles long. First-path trials never pulse `int2_share`.
- R5: On every comparator fire during the first path, `cm_hold2` is 1 and `cm_hold1` is 0. During the second path, `cm_hold1` is 1 and `cm_hold2` is 0.
- R6: Each path's search starts at code 4. A `cmp_out` of 1 in the decision cycle means the integrator path is too strong: the code is decremented by one. A `cmp_out` of 0 increments the code by one.
- R7: A path's search stops at the first trial whose decision differs from the previous trial's decision, and keeps the code used in that trial.
- R8: When a trial's decision would step the code below 0 or above 7, the search stops at that end code and sets the path's `cal_sat` bit (bit 0 for the first path, bit 1 for the second).
- R9: When the decision flips on a trial at code 0 or 7, the search stops there with no saturation.
- R10: Every first-path trial comes before every second-path trial.
- R11: `cal_done` rises when the second path finishes. `cal_done` and both codes then hold until the next `cal_start`. A `cal_start` during a running calibration is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Calibration request pulse |
| cmp_out | input | 1 | Comparator decision latched by `cmp_fire`; 1 = weighted sum positive |
| dac_code_p | output | 10 | DAC positive-side code |
| dac_code_m | output | 10 | DAC negative-side code |
| res_sample | output | 1 | Residue sampling strobe |
| int1_share | output | 1 | Charge-share strobe into the first integrator |
| int2_share | output | 1 | Charge-share strobe into the second integrator |
| cmp_fire | output | 1 | Comparator evaluation strobe |
| cm_hold1 | output | 1 | Force first integrator inputs to common mode |
| cm_hold2 | output | 1 | Force second integrator inputs to common mode |
| gain1_code | output | 3 | First integrator path gain code |
| gain2_code | output | 3 | Second integrator path gain code |
| cal_done | output | 1 | Calibration complete, results valid |
| cal_sat | output | 2 | Per-path saturation flags |

## Verification
A decision flip and a range end can occur in the same decision cycle, on the trial that runs at code 0 or 7. The bench sets up its behavioural comparator so the sign change lands exactly on an end code for each path. The result is correct only if the code stays at that end code and `cal_sat` stays clear. Separate gain tables push the search past an end code without any flip, and those runs must set the flag. A start pulse injected in the middle of a run checks that `cal_start` is ignored during a calibration, judged by an unchanged trial count and unchanged final codes.

// File: rtl/cmp_gain_cal_pkg.sv
// Shared types for the comparator gain calibration controller.
package cmp_gain_cal_pkg;
    // Sequencer states; one trial walks LOAD..DECIDE once.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_SHARE1 = 3'd3,
        ST_SHARE2 = 3'd4,
        ST_FLIP   = 3'd5,
        ST_CMP    = 3'd6,
        ST_DECIDE = 3'd7
    } cal_state_e;

    localparam int NUM_PATHS = 2;
endpackage

// File: rtl/cal_code_search.sv
// Linear gain-code search for one integrator path.
// Starts at the mid code on init_i. On each eval_i it applies the latched
// comparator decision: it steps toward the balance point, stops when the
// decision differs from the previous trial, or saturates at a range end.
// stop_o is combinational, valid in the eval cycle. Assumes eval_i is a
// single-cycle pulse per trial and is never raised together with init_i.
module cal_code_search #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              eval_i,
    input  logic              dec_i,
    output logic [CODE_W-1:0] code_o,
    output logic              sat_o,
    output logic              stop_o
);
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CODE_W-1:0] code_q;
    logic              first_q;
    logic              prev_q;
    logic              sat_q;
    logic              flip;
    logic              at_end;

    // Decision analysis for the current trial.
    always_comb begin
        flip   = !first_q && (dec_i != prev_q);
        at_end = dec_i ? (code_q == '0) : (code_q == CODE_MAX);
        stop_o = eval_i && (flip || at_end);
    end

    // Search state: code, previous decision, first-trial and saturation flags.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            code_q  <= CODE_MID;
            first_q <= 1'b1;
            prev_q  <= 1'b0;
            sat_q   <= 1'b0;
        end else if (eval_i) begin
            first_q <= 1'b0;
            prev_q  <= dec_i;
            if (!flip) begin
                if (at_end) sat_q  <= 1'b1;
                else        code_q <= dec_i ? code_q - 1'b1 : code_q + 1'b1;
            end
        end
    end

    assign code_o = code_q;
    assign sat_o  = sat_q;

    // R8: a saturated path sits at one end of the code range.
    assert_sat_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sat_q |-> (code_q == '0 || code_q == CODE_MAX));

    // R6: the code only moves on an evaluation or a restart.
    assert_code_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !eval_i) |=> $stable(code_q));

    // R6: an evaluation moves the code by at most one step.
    assert_code_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !init_i) |=> (code_q == $past(code_q) ||
                                 code_q == $past(code_q) + 1'b1 ||
                                 code_q == $past(code_q) - 1'b1));
endmodule

// File: rtl/cal_sequencer.sv
// Trial sequencer for the gain calibration.
// Walks the two-step residue experiment for path one, then path two:
// fixed DAC code, residue sample, charge share(s), complemented code,
// comparator fire, decision. Moves to the next path or to done when the
// active search reports stop. Assumes the comparator result is valid in
// the cycle after cmp_fire.
module cal_sequencer
    import cmp_gain_cal_pkg::*;
#(
    parameter int                 DAC_W      = 10,
    parameter logic [DAC_W-1:0]   CAL_CODE_P = 10'h2C0,
    parameter logic [DAC_W-1:0]   CAL_CODE_M = 10'h140
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_start,
    input  logic [NUM_PATHS-1:0] stop_i,
    output logic                 init_o,
    output logic [NUM_PATHS-1:0] eval_o,
    output logic [DAC_W-1:0]     dac_p_o,
    output logic [DAC_W-1:0]     dac_m_o,
    output logic                 res_sample_o,
    output logic                 int1_share_o,
    output logic                 int2_share_o,
    output logic                 cmp_fire_o,
    output logic                 cm_hold1_o,
    output logic                 cm_hold2_o,
    output logic                 done_o
);
    cal_state_e state_q;
    logic       path2_q;
    logic       done_q;
    logic       busy;

    // Accept a start only when no calibration is running.
    assign init_o = (state_q == ST_IDLE) && cal_start;
    assign busy   = (state_q != ST_IDLE);

    // State walk, active path and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            path2_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cal_start) begin
                    state_q <= ST_LOAD;
                    path2_q <= 1'b0;
                    done_q  <= 1'b0;
                end
                ST_LOAD:   state_q <= ST_SAMPLE;
                ST_SAMPLE: state_q <= ST_SHARE1;
                ST_SHARE1: state_q <= path2_q ? ST_SHARE2 : ST_FLIP;
                ST_SHARE2: state_q <= ST_FLIP;
                ST_FLIP:   state_q <= ST_CMP;
                ST_CMP:    state_q <= ST_DECIDE;
                ST_DECIDE: begin
                    if (!stop_i[path2_q]) begin
                        state_q <= ST_LOAD;
                    end else if (path2_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        path2_q <= 1'b1;
                        state_q <= ST_LOAD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes, DAC codes and common-mode holds decoded from the state.
    always_comb begin
        res_sample_o = (state_q == ST_SAMPLE);
        int1_share_o = (state_q == ST_SHARE1);
        int2_share_o = (state_q == ST_SHARE2);
        cmp_fire_o   = (state_q == ST_CMP);
        eval_o       = '0;
        eval_o[path2_q] = (state_q == ST_DECIDE);
        cm_hold2_o   = busy && !path2_q;
        cm_hold1_o   = path2_q && (state_q == ST_FLIP || state_q == ST_CMP ||
                                   state_q == ST_DECIDE);
        if (state_q == ST_FLIP || state_q == ST_CMP || state_q == ST_DECIDE) begin
            dac_p_o = ~CAL_CODE_P;
            dac_m_o = ~CAL_CODE_M;
        end else if (busy) begin
            dac_p_o = CAL_CODE_P;
            dac_m_o = CAL_CODE_M;
        end else begin
            dac_p_o = '0;
            dac_m_o = '0;
        end
    end

    assign done_o = done_q;

    // R3: at most one analog strobe per cycle.
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_sample_o, int1_share_o, int2_share_o, cmp_fire_o}));

    // R3: the residue sample is followed by the first charge share.
    assert_sample_then_share_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_sample_o |=> int1_share_o);

    // R5: exactly one integrator input is parked at common mode when firing.
    assert_cm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fire_o |-> (cm_hold1_o ^ cm_hold2_o));

    // R11: done holds until a new start is accepted.
    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !cal_start) |=> done_q);
endmodule

// File: rtl/cmp_gain_cal.sv
// Top of the comparator gain calibration controller.
// One sequencer drives the analog experiment; one code search per
// integrator path holds that path's gain code and saturation flag.
// Assumes cmp_out is the comparator latch output, valid the cycle after
// cmp_fire, with 1 meaning the weighted input sum is positive.
module cmp_gain_cal
    import cmp_gain_cal_pkg::*;
#(
    parameter int               CODE_W     = 3,
    parameter int               DAC_W      = 10,
    parameter logic [DAC_W-1:0] CAL_CODE_P = 10'h2C0,
    parameter logic [DAC_W-1:0] CAL_CODE_M = 10'h140
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_start,
    input  logic                 cmp_out,
    output logic [DAC_W-1:0]     dac_code_p,
    output logic [DAC_W-1:0]     dac_code_m,
    output logic                 res_sample,
    output logic                 int1_share,
    output logic                 int2_share,
    output logic                 cmp_fire,
    output logic                 cm_hold1,
    output logic                 cm_hold2,
    output logic [CODE_W-1:0]    gain1_code,
    output logic [CODE_W-1:0]    gain2_code,
    output logic                 cal_done,
    output logic [NUM_PATHS-1:0] cal_sat
);
    logic                 init_w;
    logic [NUM_PATHS-1:0] eval_w;
    logic [NUM_PATHS-1:0] stop_w;
    logic [CODE_W-1:0]    code_w [NUM_PATHS];

    cal_sequencer #(
        .DAC_W      (DAC_W),
        .CAL_CODE_P (CAL_CODE_P),
        .CAL_CODE_M (CAL_CODE_M)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_start    (cal_start),
        .stop_i       (stop_w),
        .init_o       (init_w),
        .eval_o       (eval_w),
        .dac_p_o      (dac_code_p),
        .dac_m_o      (dac_code_m),
        .res_sample_o (res_sample),
        .int1_share_o (int1_share),
        .int2_share_o (int2_share),
        .cmp_fire_o   (cmp_fire),
        .cm_hold1_o   (cm_hold1),
        .cm_hold2_o   (cm_hold2),
        .done_o       (cal_done)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        cal_code_search #(.CODE_W(CODE_W)) u_search (
            .clk    (clk),
            .rst_n  (rst_n),
            .init_i (init_w),
            .eval_i (eval_w[p]),
            .dec_i  (cmp_out),
            .code_o (code_w[p]),
            .sat_o  (cal_sat[p]),
            .stop_o (stop_w[p])
        );
    end

    assign gain1_code = code_w[0];
    assign gain2_code = code_w[1];

    // R11: the gain codes do not move while calibration results are shown.
    assert_codes_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_start) |=> ($stable(gain1_code) && $stable(gain2_code)));
endmodule

// File: tb/cmp_gain_cal_tb.sv
// Bench: behavioural charge-sharing model and three-input comparator,
// directed boundary cases plus seeded random gain tables.
module cmp_gain_cal_tb;
    localparam logic [9:0] CP = 10'h2C0;
    localparam logic [9:0] CM = 10'h140;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_start = 1'b0;
    logic       cmp_out = 1'b0;
    logic [9:0] dac_code_p, dac_code_m;
    logic       res_sample, int1_share, int2_share, cmp_fire, cm_hold1, cm_hold2;
    logic [2:0] gain1_code, gain2_code;
    logic       cal_done;
    logic [1:0] cal_sat;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // gain tables in eighths: gain(code) = base + slope*code
    int base1, slope1, base2, slope2;
    int res_q, v1_q, v2_q;
    int n_tr1, n_tr2;
    bit saw_int2, saw_path2;

    always #2 clk = ~clk;

    cmp_gain_cal u_dut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cmp_out(cmp_out),
        .dac_code_p(dac_code_p), .dac_code_m(dac_code_m),
        .res_sample(res_sample), .int1_share(int1_share), .int2_share(int2_share),
        .cmp_fire(cmp_fire), .cm_hold1(cm_hold1), .cm_hold2(cm_hold2),
        .gain1_code(gain1_code), .gain2_code(gain2_code),
        .cal_done(cal_done), .cal_sat(cal_sat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural analog: residue capture, charge shares, comparator latch.
    always @(posedge clk) begin
        int vdac, val;
        vdac = int'(dac_code_p) - int'(dac_code_m);
        if (res_sample) res_q <= vdac;
        if (int1_share) v1_q  <= res_q;   // represents residue/4
        if (int2_share) v2_q  <= v1_q;    // represents residue/16
        if (cmp_fire) begin
            // scaled by 128: DAC term + k1*res/4 + k2*res/16, k in eighths
            val = 128 * vdac;
            if (!cm_hold1) val += 4 * (base1 + slope1 * int'(gain1_code)) * v1_q;
            if (!cm_hold2) val += (base2 + slope2 * int'(gain2_code)) * v2_q;
            cmp_out <= (val > 0);
        end
    end

    // Trial monitor: path order and common-mode holds (R4, R5, R10).
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_sample) saw_int2 = 1'b0;
            if (int2_share) saw_int2 = 1'b1;
            if (cmp_fire) begin
                if (saw_int2) begin
                    n_tr2++;
                    saw_path2 = 1'b1;
                    chk(cm_hold1 && !cm_hold2, "R5 path2 holds", {cm_hold1, cm_hold2}, 2);
                end else begin
                    n_tr1++;
                    chk(!saw_path2, "R10 path1 after path2", 1, 0);
                    chk(cm_hold2 && !cm_hold1, "R5 path1 holds", {cm_hold1, cm_hold2}, 1);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Expected search result from the requirements R6..R9.
    task automatic expect_search(input int base, input int slope, input int target,
                                 output int code, output int sat, output int trials);
        bit first = 1'b1;
        bit prev = 1'b0;
        code = 4; sat = 0; trials = 0;
        for (int i = 0; i < 16; i++) begin
            bit d;
            trials++;
            d = (base + slope * code) > target;
            if (!first && d != prev) break;
            if (d && code == 0) begin sat = 1; break; end
            if (!d && code == 7) begin sat = 1; break; end
            prev = d; first = 1'b0;
            code = d ? code - 1 : code + 1;
        end
    endtask

    task automatic run_cal(input int b1, input int s1, input int b2, input int s2,
                           input bit timing, input bit busy_start, input string tag);
        int ec1, es1, et1, ec2, es2, et2, waited;
        base1 = b1; slope1 = s1; base2 = b2; slope2 = s2;
        expect_search(b1, s1, 32, ec1, es1, et1);
        expect_search(b2, s2, 128, ec2, es2, et2);
        n_tr1 = 0; n_tr2 = 0; saw_path2 = 1'b0; saw_int2 = 1'b0;
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        // R2: restart clears done and flags, codes back to mid
        chk(!cal_done && cal_sat == 2'b00, "R2 cleared", {cal_done, cal_sat}, 0);
        chk(gain1_code == 3'd4 && gain2_code == 3'd4, "R2 mid codes",
            {gain1_code, gain2_code}, 36);
        if (timing) begin
            // R3: cycle 1 fixed code, no strobe
            chk(dac_code_p == CP && dac_code_m == CM && !res_sample && !int1_share,
                "R3 load", int'(dac_code_p), int'(CP));
            @(negedge clk);
            chk(res_sample && dac_code_p == CP, "R3 sample", res_sample, 1);
            @(negedge clk);
            chk(int1_share && !int2_share && dac_code_m == CM, "R3 share1", int1_share, 1);
            @(negedge clk);
            chk(!cmp_fire && !int2_share && dac_code_p == ~CP && dac_code_m == ~CM,
                "R4 R3 flip", int'(dac_code_p), int'(~CP));
            @(negedge clk);
            chk(cmp_fire && dac_code_p == ~CP, "R3 fire", cmp_fire, 1);
        end
        waited = 0;
        while (!cal_done && waited < 400) begin
            @(negedge clk);
            waited++;
            if (busy_start && waited == 9) cal_start = 1'b1;
            if (busy_start && waited == 10) cal_start = 1'b0;
        end
        chk(cal_done, {"R11 done ", tag}, cal_done, 1);
        chk(gain1_code == 3'(ec1), {"R6 R7 code1 ", tag}, gain1_code, ec1);
        chk(gain2_code == 3'(ec2), {"R6 R7 code2 ", tag}, gain2_code, ec2);
        chk(cal_sat == {1'(es2), 1'(es1)}, {"R8 R9 sat ", tag}, cal_sat, es2 * 2 + es1);
        chk(n_tr1 == et1 && n_tr2 == et2, {"R6 R10 trials ", tag},
            n_tr1 * 100 + n_tr2, et1 * 100 + et2);
        // R11: results hold while idle
        repeat (12) @(negedge clk);
        chk(cal_done && gain1_code == 3'(ec1) && gain2_code == 3'(ec2),
            {"R11 hold ", tag}, {gain1_code, gain2_code}, ec1 * 8 + ec2);
    endtask

    initial begin
        void'($urandom(32'd4242));
        base1 = 0; slope1 = 0; base2 = 0; slope2 = 0;
        res_q = 0; v1_q = 0; v2_q = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(gain1_code == 3'd4 && gain2_code == 3'd4, "R1 codes", {gain1_code, gain2_code}, 36);
        chk(!cal_done && cal_sat == 0 && !res_sample && !int1_share && !int2_share &&
            !cmp_fire && !cm_hold1 && !cm_hold2 && dac_code_p == 0 && dac_code_m == 0,
            "R1 outputs", {cal_done, cal_sat}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: upward flip / flip to code 5, timing checked (R3, R7)
        run_cal(20, 3, 100, 6, 1'b1, 1'b0, "up");
        // R9: flip landing on code 0 for both paths
        run_cal(30, 3, 120, 10, 1'b0, 1'b0, "flip0");
        // R8: saturate low on path1, high on path2
        run_cal(40, 3, 10, 5, 1'b0, 1'b0, "sat");
        // R9: flip at code 7 on path1, R8 sat low on path2
        run_cal(12, 3, 200, 10, 1'b0, 1'b0, "flip7");
        // R11: start during a run is ignored
        run_cal(26, 2, 90, 9, 1'b0, 1'b1, "busy");
        for (int i = 0; i < 10; i++) begin
            int s1 = 3 + int'($urandom_range(5));
            int b1 = int'($urandom_range(40));
            int s2 = 8 + int'($urandom_range(16));
            int b2 = 60 + int'($urandom_range(140));
            run_cal(b1, s1, b2, s2, 1'b0, 1'b0, "rand");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule